// File: doc/BRIEF.md
# Two-Wire Host Register Interface

This block is the slave end of a synchronous two-wire serial link of the shift-register kind. The host owns the link clock, which toggles only while a transfer is in progress. A single data line carries bits in both directions; at the chip edge it is split into an input, an output and an output enable. Every transfer opens with an 8-bit address sent least significant bit first. If address bit 7 is clear, the host follows it with 8 data bits, also least significant bit first. If bit 7 is set, the slave drives 8 bits back. There is no start or stop framing. Bit phase is restored only by a separate link reset line.

Writes to six consecutive addresses load six byte-wide settings registers. Four further addresses work as commands without data: the address itself sets a field-select and a median-select output. The data byte after a command is a dummy and is discarded. Two read addresses return the low and high bytes of a 16-bit correlation value supplied by the surrounding logic. The link clock, link data and link reset are brought into the system clock domain through two-flop synchronizers. The system clock is assumed to run at least 20 times faster than the link clock.

Top module: `hostlink_regs`

## Requirements
- R1: Address and data bytes are assembled least significant bit first, one bit per rising edge of the link clock. After 8 address bits the next 8 bits form the data byte.
- R2: A write to address 0x01, 0x02, 0x03, 0x04, 0x05 or 0x06 loads the data byte into `fmt_o`, `grey_o`, `rden_o`, `zoom_o`, `cti_o` or `peak_o` respectively.
- R3: A write to any address from 0x00 to 0x7F other than 0x01–0x06 changes no settings register.
- R4: When the address byte is 0x7C–0x7F, `sel_field_o` takes address bit 0 and `sel_median_o` takes address bit 1 as soon as the address byte completes. The data byte that follows is discarded.
- R5: A read of 0x80 returns `corr_i[7:0]` and a read of 0x81 returns `corr_i[15:8]`, least significant bit first on `dat_o`. The value is captured when the address byte completes. Every other read address returns 0x00.
- R6: `dat_oe_o` rises only after the 8th bit of a read address and falls after the 8th returned bit. It stays low throughout write transfers.
- R7: A falling edge of `lrst_i` clears the bit phase and the address register and releases `dat_oe_o`. The next bit received is address bit 0.
- R8: While `rst_ni` is low, all settings and both selects are 0 and `dat_oe_o` is low.
- R9: An address with bit 7 set is a read and never alters a settings register.
- R10: A settings register changes on the third system clock edge after the 8th data-bit rising edge of the link clock is applied at the pin, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| lclk_i | input | 1 | Link clock from the host |
| ldat_i | input | 1 | Link data from the host |
| lrst_i | input | 1 | Link reset; its falling edge restarts bit phase |
| corr_i | input | 16 | Correlation value returned by reads |
| dat_o | output | 1 | Link data driven by the slave |
| dat_oe_o | output | 1 | Output enable for the shared data line |
| fmt_o | output | 8 | Settings register at address 0x01 |
| grey_o | output | 8 | Settings register at address 0x02 |
| rden_o | output | 8 | Settings register at address 0x03 |
| zoom_o | output | 8 | Settings register at address 0x04 |
| cti_o | output | 8 | Settings register at address 0x05 |
| peak_o | output | 8 | Settings register at address 0x06 |
| sel_field_o | output | 1 | Field select, set by command addresses |
| sel_median_o | output | 1 | Median select, set by command addresses |

## Verification
The assertions assume that each link clock level lasts several system clocks, so every host edge shows up as exactly one detected edge after synchronization. They also assume that link data is stable across each rising edge and that the link reset is not pulsed in the same system cycle as a link clock edge. The bench holds every link clock phase for 20 system clocks. It changes data only while the link clock is low, and it pulses the link reset only while the link clock is idle low.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CNT_W     = $clog2(BYTE_W);
  localparam int unsigned NUM_CFG   = 6;
  localparam int unsigned CORR_W    = 16;
  localparam int unsigned NUM_RD    = CORR_W / BYTE_W;
  localparam logic [BYTE_W-1:0] CFG_FIRST = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_MASK  = 8'hFC;
  localparam logic [BYTE_W-1:0] CMD_MATCH = 8'h7C;
  localparam logic [BYTE_W-1:0] RD_BASE   = 8'h80;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/hostlink_sync.sv
module hostlink_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hostlink_frame.sv
module hostlink_frame
  import hostlink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lclk_i,
  input  logic              ldat_i,
  input  logic              lrst_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic              cmd_stb_o,
  output logic              dat_o,
  output logic              dat_oe_o
);
  logic              lclk_prev_q, lrst_prev_q;
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              oe_q, oe_d;
  logic              rise_w, lrst_fall_w, last_w;
  logic [BYTE_W-1:0] rx_w;

  assign rise_w      = lclk_i & ~lclk_prev_q;
  assign lrst_fall_w = ~lrst_i & lrst_prev_q;
  assign last_w      = (cnt_q == CNT_W'(BYTE_W - 1));
  assign rx_w        = {ldat_i, shift_q[BYTE_W-1:1]};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    addr_d  = addr_q;
    tx_d    = tx_q;
    oe_d    = oe_q;
    if (lrst_fall_w) begin
      phase_d = PH_ADDR;
      cnt_d   = '0;
      shift_d = '0;
      addr_d  = '0;
      oe_d    = 1'b0;
    end else if (rise_w) begin
      cnt_d = cnt_q + 1'b1;
      if (phase_q == PH_ADDR) begin
        shift_d = rx_w;
        if (last_w) begin
          addr_d  = rx_w;
          phase_d = PH_DATA;
          cnt_d   = '0;
          if (rx_w[BYTE_W-1]) begin
            tx_d = rd_byte_i;
            oe_d = 1'b1;
          end
        end
      end else begin
        if (addr_q[BYTE_W-1]) tx_d = tx_q >> 1;
        else                  shift_d = rx_w;
        if (last_w) begin
          phase_d = PH_ADDR;
          cnt_d   = '0;
          oe_d    = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lclk_prev_q <= 1'b0;
      lrst_prev_q <= 1'b0;
      phase_q     <= PH_ADDR;
      cnt_q       <= '0;
      shift_q     <= '0;
      addr_q      <= '0;
      tx_q        <= '0;
      oe_q        <= 1'b0;
    end else begin
      lclk_prev_q <= lclk_i;
      lrst_prev_q <= lrst_i;
      phase_q     <= phase_d;
      cnt_q       <= cnt_d;
      shift_q     <= shift_d;
      addr_q      <= addr_d;
      tx_q        <= tx_d;
      oe_q        <= oe_d;
    end
  end

  assign rx_byte_o = rx_w;
  assign wr_stb_o  = rise_w && !lrst_fall_w && (phase_q == PH_DATA) && last_w
                     && !addr_q[BYTE_W-1];
  assign wr_addr_o = addr_q;
  assign cmd_stb_o = rise_w && !lrst_fall_w && (phase_q == PH_ADDR) && last_w
                     && ((rx_w & CMD_MASK) == CMD_MATCH);
  assign dat_o     = tx_q[0];
  assign dat_oe_o  = oe_q;

  // R6
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> ($past(rise_w) && $past(phase_q) == PH_ADDR));
  // R6
  oe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> ($past(rise_w) || $past(lrst_fall_w)));
  // R7
  lrst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst_fall_w |=> (cnt_q == '0 && phase_q == PH_ADDR && !oe_q && addr_q == '0));
  // R1
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_w && !lrst_fall_w) |=> ($stable(cnt_q) && $stable(phase_q)));
endmodule

// File: rtl/hostlink_regfile.sv
module hostlink_regfile
  import hostlink_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_stb_i,
  input  logic [BYTE_W-1:0]              wr_addr_i,
  input  logic [BYTE_W-1:0]              wr_data_i,
  input  logic                           cmd_stb_i,
  input  logic [BYTE_W-1:0]              cmd_addr_i,
  input  logic [BYTE_W-1:0]              rd_addr_i,
  input  logic [CORR_W-1:0]              corr_i,
  output logic [BYTE_W-1:0]              rd_byte_o,
  output logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_o,
  output logic [1:0]                     sel_o
);
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic              hit_w;
    logic [BYTE_W-1:0] val_q;
    assign hit_w = wr_stb_i && (wr_addr_i == CFG_FIRST + BYTE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    val_q <= '0;
      else if (hit_w) val_q <= wr_data_i;
    end
    assign cfg_o[g] = val_q;
  end

  logic [1:0] sel_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= '0;
    else if (cmd_stb_i) sel_q <= cmd_addr_i[1:0];
  end
  assign sel_o = sel_q;

  always_comb begin
    rd_byte_o = '0;
    for (int b = 0; b < NUM_RD; b++) begin
      if (rd_addr_i == RD_BASE + BYTE_W'(b)) rd_byte_o = corr_i[b*BYTE_W +: BYTE_W];
    end
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(cfg_o));
  // R4
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_stb_i |=> $stable(sel_o));
  // R4
  sel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_i |=> (sel_o == $past(cmd_addr_i[1:0])));
  // R9
  wr_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |-> !wr_addr_i[BYTE_W-1]);
endmodule

// File: rtl/hostlink_regs.sv
module hostlink_regs
  import hostlink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lclk_i,
  input  logic              ldat_i,
  input  logic              lrst_i,
  input  logic [CORR_W-1:0] corr_i,
  output logic              dat_o,
  output logic              dat_oe_o,
  output logic [BYTE_W-1:0] fmt_o,
  output logic [BYTE_W-1:0] grey_o,
  output logic [BYTE_W-1:0] rden_o,
  output logic [BYTE_W-1:0] zoom_o,
  output logic [BYTE_W-1:0] cti_o,
  output logic [BYTE_W-1:0] peak_o,
  output logic              sel_field_o,
  output logic              sel_median_o
);
  logic [2:0]                     sync_w;
  logic [BYTE_W-1:0]              rx_byte_w, wr_addr_w, rd_byte_w;
  logic                           wr_stb_w, cmd_stb_w;
  logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_w;
  logic [1:0]                     sel_w;

  hostlink_sync #(.W(3), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({lrst_i, ldat_i, lclk_i}),
    .q_o    (sync_w)
  );

  hostlink_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lclk_i    (sync_w[0]),
    .ldat_i    (sync_w[1]),
    .lrst_i    (sync_w[2]),
    .rd_byte_i (rd_byte_w),
    .rx_byte_o (rx_byte_w),
    .wr_stb_o  (wr_stb_w),
    .wr_addr_o (wr_addr_w),
    .cmd_stb_o (cmd_stb_w),
    .dat_o     (dat_o),
    .dat_oe_o  (dat_oe_o)
  );

  hostlink_regfile u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb_w),
    .wr_addr_i  (wr_addr_w),
    .wr_data_i  (rx_byte_w),
    .cmd_stb_i  (cmd_stb_w),
    .cmd_addr_i (rx_byte_w),
    .rd_addr_i  (rx_byte_w),
    .corr_i     (corr_i),
    .rd_byte_o  (rd_byte_w),
    .cfg_o      (cfg_w),
    .sel_o      (sel_w)
  );

  assign fmt_o        = cfg_w[0];
  assign grey_o       = cfg_w[1];
  assign rden_o       = cfg_w[2];
  assign zoom_o       = cfg_w[3];
  assign cti_o        = cfg_w[4];
  assign peak_o       = cfg_w[5];
  assign sel_field_o  = sel_w[0];
  assign sel_median_o = sel_w[1];
endmodule

// File: tb/hostlink_regs_tb.sv
module hostlink_regs_tb;
  localparam int HALF = 20;
  localparam int NV   = 12;
  // entry: {is_write, addr, wdata, expected}
  localparam logic [31:0] VEC [NV] = '{
    {8'h01, 8'h01, 8'h3C, 8'h3C}, {8'h01, 8'h02, 8'hF0, 8'hF0},
    {8'h01, 8'h03, 8'h81, 8'h81}, {8'h01, 8'h04, 8'h5A, 8'h5A},
    {8'h01, 8'h05, 8'hC3, 8'hC3}, {8'h01, 8'h06, 8'h7E, 8'h7E},
    {8'h00, 8'h80, 8'h00, 8'h5C}, {8'h00, 8'h81, 8'h00, 8'hA5},
    {8'h00, 8'h82, 8'h00, 8'h00}, {8'h00, 8'hFF, 8'h00, 8'h00},
    {8'h01, 8'h01, 8'h00, 8'h00}, {8'h01, 8'h06, 8'hFF, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lclk = 1'b0, ldat = 1'b0, lrst = 1'b0;
  logic [15:0] corr = 16'hA55C;
  logic dat_o, dat_oe;
  logic [7:0] fmt, grey, rden, zoom, cti, peak;
  logic sel_f, sel_m;
  int n_vec = 0, n_bad = 0;
  logic done = 1'b0;
  logic [7:0] model [6];

  always #2 clk = ~clk;

  hostlink_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lclk_i(lclk), .ldat_i(ldat), .lrst_i(lrst),
    .corr_i(corr), .dat_o(dat_o), .dat_oe_o(dat_oe), .fmt_o(fmt), .grey_o(grey),
    .rden_o(rden), .zoom_o(zoom), .cti_o(cti), .peak_o(peak),
    .sel_field_o(sel_f), .sel_median_o(sel_m)
  );

  function automatic logic [7:0] cfg_at(input int i);
    case (i)
      0: return fmt;  1: return grey; 2: return rden;
      3: return zoom; 4: return cti;  default: return peak;
    endcase
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    for (int i = 0; i < 6; i++) check8(req, cfg_at(i), model[i]);
  endtask

  task automatic xfer_bit(input logic b, output logic s, output logic o);
    ldat = b;
    repeat (HALF) @(negedge clk);
    s = dat_o;
    o = dat_oe;
    lclk = 1'b1;
    repeat (HALF) @(negedge clk);
    lclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic oe_any);
    logic s, o;
    oe_any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      xfer_bit(v[i], s, o);
      oe_any |= o;
    end
  endtask

  task automatic write_txn(input logic [7:0] a, input logic [7:0] d);
    logic oa, ob;
    send_byte(a, oa);
    send_byte(d, ob);
    repeat (4) @(negedge clk);
    // R6: output enable never set during a write
    check8("R6", {7'd0, oa | ob | dat_oe}, 8'h00);
    if (a >= 8'h01 && a <= 8'h06) model[a - 8'h01] = d;
  endtask

  task automatic read_txn(input logic [7:0] a, output logic [7:0] v, output logic oe_all);
    logic oa, s, o;
    send_byte(a, oa);
    oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      xfer_bit(1'b0, s, o);
      v[i] = s;
      oe_all &= o;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic link_reset();
    lrst = 1'b1;
    repeat (10) @(negedge clk);
    lrst = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic oe_all, s, o, oa;
    for (int i = 0; i < 6; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R8: reset state
    check_model("R8");
    check8("R8", {6'd0, sel_m, sel_f}, 8'h00);
    check8("R8", {7'd0, dat_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_model("R8");

    // R1 R2 R5: vector table
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][24]) begin
        write_txn(VEC[k][23:16], VEC[k][15:8]);
        check8("R2", cfg_at(int'(VEC[k][23:16]) - 1), VEC[k][7:0]);
      end else begin
        read_txn(VEC[k][23:16], rv, oe_all);
        check8("R5", rv, VEC[k][7:0]);
        // R6: enable held for all returned bits, released after
        check8("R6", {6'd0, oe_all, dat_oe}, 8'h02);
      end
    end

    // R9: reads leave settings alone
    check_model("R9");

    // R5: new correlation value
    corr = 16'h1234;
    read_txn(8'h81, rv, oe_all);
    check8("R5", rv, 8'h12);
    read_txn(8'h80, rv, oe_all);
    check8("R5", rv, 8'h34);

    // R3: unused write addresses
    write_txn(8'h07, 8'hEE);
    write_txn(8'h00, 8'hEE);
    write_txn(8'h40, 8'hEE);
    check_model("R3");
    check8("R3", {6'd0, sel_m, sel_f}, 8'h00);

    // R4: command addresses, selects set by address bits, dummy ignored
    send_byte(8'h7D, oa);
    repeat (4) @(negedge clk);
    check8("R4", {6'd0, sel_m, sel_f}, 8'h01);
    send_byte(8'hFF, oa);
    repeat (4) @(negedge clk);
    check_model("R4");
    check8("R4", {6'd0, sel_m, sel_f}, 8'h01);
    write_txn(8'h7E, 8'h00);
    check8("R4", {6'd0, sel_m, sel_f}, 8'h02);
    write_txn(8'h7F, 8'h55);
    check8("R4", {6'd0, sel_m, sel_f}, 8'h03);
    write_txn(8'h7C, 8'hAA);
    check8("R4", {6'd0, sel_m, sel_f}, 8'h00);
    check_model("R4");

    // R7: link reset in the middle of an address byte
    xfer_bit(1'b1, s, o);
    xfer_bit(1'b1, s, o);
    xfer_bit(1'b1, s, o);
    link_reset();
    write_txn(8'h03, 8'h11);
    check8("R7", rden, 8'h11);
    check_model("R7");

    // R7: link reset in the middle of a read releases the line
    send_byte(8'h80, oa);
    xfer_bit(1'b0, s, o);
    xfer_bit(1'b0, s, o);
    check8("R7", {7'd0, dat_oe}, 8'h01);
    link_reset();
    check8("R7", {7'd0, dat_oe}, 8'h00);
    write_txn(8'h02, 8'hA5);
    check8("R7", grey, 8'hA5);

    // R10: update latency after the final data-bit rising edge
    send_byte(8'h04, oa);
    for (int i = 0; i < 7; i++) xfer_bit(1'b1, s, o);
    ldat = 1'b0;
    repeat (HALF) @(negedge clk);
    lclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check8("R10", zoom, 8'h5A);
    @(negedge clk);
    check8("R10", zoom, 8'h7F);
    repeat (HALF) @(negedge clk);
    lclk = 1'b0;
    model[3] = 8'h7F;
    repeat (4) @(negedge clk);
    check_model("R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule